// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status Flags

This block receives 8-bit characters from an asynchronous serial line. A baud tick arrives at sixteen times the bit rate. The block synchronises the line, finds a start bit, samples each data bit and stop bit once in the middle of the bit, and writes the character into a receive data register. A small status register holds three sticky flags: data ready, framing error and overrun. A simple register-bus host reads these flags and clears them. The flags are also driven out as level outputs.

A frame whose first stop bit is low still writes its byte into the data register. It does not raise the data-ready flag. Instead it raises the framing-error flag, and the receiver then ignores the line until software clears that flag. A flag clears only when the host writes a 0 to it after a status read that returned it as 1. Turning the receiver off leaves the framing-error flag as it is. Reset and the standby input both force the framing-error flag to 0.

Top module: `async_rx_status`

## Requirements
- R1: After reset, the data register reads 0 and all three status flags read 0.
- R2: A frame is one low start bit, then 8 data bits sent least significant bit first, then a high stop bit. Each bit lasts 16 ticks. Such a frame loads the byte into the data register (address 0) and sets data-ready (status bit 0, address 1) in the same cycle.
- R3: If the first stop bit is sampled low, the byte is still loaded into the data register, data-ready stays 0, and framing-error (status bit 1) is set.
- R4: When two-stop mode is selected, only the first stop bit is checked. A low second stop bit causes no framing error.
- R5: While framing-error is 1, start bits are ignored. No byte is received and the data register keeps its value.
- R6: A status flag clears only when the host writes 0 to that bit after a status read that returned the bit as 1. A write of 0 with no such prior read does nothing. Writing 1 never sets a flag.
- R7: While receive-enable is low, no frame is received, and the framing-error flag keeps its value.
- R8: The standby input forces framing-error to 0 within one cycle.
- R9: A low pulse on the line that is high again at the start bit's midpoint (tick 8) is rejected. No frame is received.
- R10: If a frame completes with a good stop bit while data-ready is 1, overrun (status bit 2) is set and the data register keeps its earlier byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby_i | input | 1 | Standby request; clears the framing-error flag |
| rx_en_i | input | 1 | Receive enable |
| two_stop_i | input | 1 | Two-stop-bit frame format |
| tick_i | input | 1 | Oversampling tick at 16x the bit rate |
| rxd_i | input | 1 | Serial receive line, idle high |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 1 | 0 = data register, 1 = status register |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| rdf_o | output | 1 | Data-ready flag level |
| fe_o | output | 1 | Framing-error flag level |
| ovr_o | output | 1 | Overrun flag level |

## Verification
A table of frames sends bytes with alternating, all-zero and all-one bit patterns, in both one-stop and two-stop formats, with each stop bit driven high or low. These cases separate correct bit order and sampling from shifted or reversed capture. They also show that only the first stop bit decides a framing error. Directed sequences then cover the clearing handshake with and without a prior read, frames sent while an error is pending or while the receiver is disabled, standby, a short start glitch, and a second frame arriving before the first is read.

// File: rtl/srx_pkg.sv
package srx_pkg;
   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP1,
      RX_STOP2
   } rx_state_t;

   localparam int ST_RDF = 0;
   localparam int ST_FE  = 1;
   localparam int ST_OVR = 2;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout,
   output logic fall
);
   logic last_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], din};
         end
         assign dout = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b1;
      else        last_q <= dout;
   end

   assign fall = last_q & ~dout;
endmodule

// File: rtl/srx_fsm.sv
module srx_fsm
   import srx_pkg::*;
#(
   parameter int OVS       = 16,
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 halt,
   input  logic                 two_stop,
   input  logic                 tick,
   input  logic                 rx,
   input  logic                 fall,
   output logic                 done,
   output logic                 stop_ok,
   output logic [DATA_BITS-1:0] shreg
);
   localparam int CW   = $clog2(OVS);
   localparam int IW   = $clog2(DATA_BITS);
   localparam int HALF = OVS / 2;

   rx_state_t     state;
   logic [CW-1:0] cnt;
   logic [IW-1:0] idx;
   logic          last_tick;

   assign last_tick = tick && (cnt == CW'(OVS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         cnt     <= '0;
         idx     <= '0;
         shreg   <= '0;
         done    <= 1'b0;
         stop_ok <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick && state != RX_IDLE) cnt <= cnt + 1'b1;
         if (!en) begin
            state <= RX_IDLE;
         end else begin
            case (state)
               RX_IDLE: begin
                  if (fall && !halt) begin
                     state <= RX_START;
                     cnt   <= '0;
                  end
               end
               RX_START: begin
                  if (tick && cnt == CW'(HALF - 1)) begin
                     cnt <= '0;
                     idx <= '0;
                     state <= rx ? RX_IDLE : RX_DATA;
                  end
               end
               RX_DATA: begin
                  if (last_tick) begin
                     shreg <= {rx, shreg[DATA_BITS-1:1]};
                     if (idx == IW'(DATA_BITS - 1)) state <= RX_STOP1;
                     else                           idx   <= idx + 1'b1;
                  end
               end
               RX_STOP1: begin
                  if (last_tick) begin
                     if (rx && two_stop) begin
                        state <= RX_STOP2;
                     end else begin
                        state   <= RX_IDLE;
                        done    <= 1'b1;
                        stop_ok <= rx;
                     end
                  end
               end
               RX_STOP2: begin
                  if (last_tick) begin
                     state   <= RX_IDLE;
                     done    <= 1'b1;
                     stop_ok <= 1'b1;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/srx_flags.sv
module srx_flags
   import srx_pkg::*;
#(
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 standby,
   input  logic                 done,
   input  logic                 stop_ok,
   input  logic [DATA_BITS-1:0] shreg,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic                 bus_addr,
   input  logic [DATA_BITS-1:0] bus_wdata,
   output logic [DATA_BITS-1:0] bus_rdata,
   output logic [DATA_BITS-1:0] data_q,
   output logic [2:0]           flags
);
   localparam int PAD = DATA_BITS - 3;

   logic [2:0] seen_q;
   logic       rd_st, wr_st;

   assign rd_st = bus_sel && !bus_wr &&  bus_addr;
   assign wr_st = bus_sel &&  bus_wr &&  bus_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags  <= '0;
         seen_q <= '0;
         data_q <= '0;
      end else begin
         if (rd_st) seen_q <= flags;
         if (wr_st) begin
            seen_q <= '0;
            for (int i = 0; i < 3; i++)
               if (seen_q[i] && !bus_wdata[i]) flags[i] <= 1'b0;
         end
         if (done) begin
            if (stop_ok) begin
               if (flags[ST_RDF]) begin
                  flags[ST_OVR] <= 1'b1;
               end else begin
                  data_q        <= shreg;
                  flags[ST_RDF] <= 1'b1;
               end
            end else begin
               data_q       <= shreg;
               flags[ST_FE] <= 1'b1;
            end
         end
         if (standby) flags[ST_FE] <= 1'b0;
      end
   end

   assign bus_rdata = bus_addr ? {{PAD{1'b0}}, flags} : data_q;
endmodule

// File: rtl/async_rx_status.sv
module async_rx_status
   import srx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int DATA_BITS   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 standby_i,
   input  logic                 rx_en_i,
   input  logic                 two_stop_i,
   input  logic                 tick_i,
   input  logic                 rxd_i,
   input  logic                 bus_sel_i,
   input  logic                 bus_wr_i,
   input  logic                 bus_addr_i,
   input  logic [DATA_BITS-1:0] bus_wdata_i,
   output logic [DATA_BITS-1:0] bus_rdata_o,
   output logic                 rdf_o,
   output logic                 fe_o,
   output logic                 ovr_o
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (DATA_BITS < 3) begin : g_bad_width
         $error("DATA_BITS must be at least 3");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic                 rx_s, rx_fall;
   logic                 frame_done, frame_ok;
   logic [DATA_BITS-1:0] frame_bits, data_q;
   logic [2:0]           flags;

   srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rxd_i), .dout(rx_s), .fall(rx_fall)
   );

   srx_fsm #(.OVS(OVS), .DATA_BITS(DATA_BITS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .en(rx_en_i), .halt(flags[ST_FE]),
      .two_stop(two_stop_i), .tick(tick_i), .rx(rx_s), .fall(rx_fall),
      .done(frame_done), .stop_ok(frame_ok), .shreg(frame_bits)
   );

   srx_flags #(.DATA_BITS(DATA_BITS)) u_flags (
      .clk(clk), .rst_n(rst_n), .standby(standby_i),
      .done(frame_done), .stop_ok(frame_ok), .shreg(frame_bits),
      .bus_sel(bus_sel_i), .bus_wr(bus_wr_i), .bus_addr(bus_addr_i),
      .bus_wdata(bus_wdata_i), .bus_rdata(bus_rdata_o),
      .data_q(data_q), .flags(flags)
   );

   assign rdf_o = flags[ST_RDF];
   assign fe_o  = flags[ST_FE];
   assign ovr_o = flags[ST_OVR];
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
   parameter int DATA_BITS = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 standby,
   input logic                 bus_sel,
   input logic                 bus_wr,
   input logic                 bus_addr,
   input logic                 done,
   input logic                 ok,
   input logic                 rdf,
   input logic                 fe,
   input logic [DATA_BITS-1:0] data_q
);
   // R2: a good frame with no pending byte raises data-ready
   assert_rdf_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ok && !rdf) |=> rdf);

   // R5: no frame completes while a framing error is pending
   assert_halt_on_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fe |-> !done);

   // R6: framing error holds unless a status write or standby occurs
   assert_fe_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fe && !standby && !(bus_sel && bus_wr && bus_addr)) |=> fe);

   // R6: only a completed frame can raise the framing error
   assert_fe_no_bus_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!fe && !done) |=> !fe);

   // R8: standby clears the framing error
   assert_standby_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> !fe);

   // R10: an overrunning frame leaves the data register untouched
   assert_overrun_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ok && rdf) |=> $stable(data_q));
endmodule

bind async_rx_status srx_checker #(.DATA_BITS(DATA_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .standby(standby_i),
   .bus_sel(bus_sel_i), .bus_wr(bus_wr_i), .bus_addr(bus_addr_i),
   .done(frame_done), .ok(frame_ok), .rdf(rdf_o), .fe(fe_o), .data_q(data_q)
);

// File: tb/sim_async_rx_status.sv
module sim_async_rx_status;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       standby = 1'b0, rx_en = 1'b1, two_stop = 1'b0;
   logic       rxd = 1'b1;
   logic       sel = 1'b0, wr = 1'b0, addr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       rdf, fe, ovr;
   int         total = 0, bad = 0;

   always #10 clk = ~clk;

   async_rx_status u0 (
      .clk(clk), .rst_n(rst_n), .standby_i(standby), .rx_en_i(rx_en),
      .two_stop_i(two_stop), .tick_i(1'b1), .rxd_i(rxd),
      .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .rdf_o(rdf), .fe_o(fe), .ovr_o(ovr)
   );

   // {byte, two_stop, stop1, stop2, expected data-ready, expected framing error}
   localparam logic [12:0] VEC [0:5] = '{
      {8'hA5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
      {8'h3C, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
      {8'h81, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
      {8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
      {8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
      {8'h5A, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hold_bit(input logic v);
      rxd = v;
      repeat (16) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] b, input logic s1, input logic s2, input logic two);
      @(negedge clk);
      hold_bit(1'b0);
      for (int i = 0; i < 8; i++) hold_bit(b[i]);
      hold_bit(s1);
      if (two) hold_bit(s2);
      rxd = 1'b1;
      repeat (24) @(negedge clk);
   endtask

   task automatic bus_read(input logic a, output logic [7:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = a;
      #2 d = rdata;
      @(negedge clk);
      sel = 1'b0;
   endtask

   task automatic bus_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic clear_all();
      logic [7:0] d;
      bus_read(1'b1, d);
      bus_write(1'b1, 8'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      bus_read(1'b1, d); check("R1 status", d, 8'h00);
      bus_read(1'b0, d); check("R1 data", d, 8'h00);

      // Table of frames: R2, R3, R4
      foreach (VEC[k]) begin
         two_stop = VEC[k][4];
         send(VEC[k][12:5], VEC[k][3], VEC[k][2], VEC[k][4]);
         bus_read(1'b1, d);
         check(VEC[k][0] ? "R3 status" : (VEC[k][4] ? "R4 status" : "R2 status"),
               d, {6'b0, VEC[k][0], VEC[k][1]});
         bus_read(1'b0, d); check("R2 data", d, VEC[k][12:5]);
         clear_all();
         bus_read(1'b1, d); check("R6 cleared", d, 8'h00);
      end
      two_stop = 1'b0;

      // R6 write 0 with no prior read; then write 1s
      send(8'h11, 1'b0, 1'b1, 1'b0);
      bus_write(1'b1, 8'h00);
      check("R6 no-read write", {7'b0, fe}, 8'h01);
      // R5 frame while error pending is ignored
      send(8'h22, 1'b1, 1'b1, 1'b0);
      bus_read(1'b1, d); check("R5 status", d, 8'h02);
      bus_read(1'b0, d); check("R5 data", d, 8'h11);
      // R7 disabling receiver keeps error
      rx_en = 1'b0;
      repeat (10) @(negedge clk);
      check("R7 fe kept", {7'b0, fe}, 8'h01);
      rx_en = 1'b1;
      // R8 standby clears error
      @(negedge clk); standby = 1'b1;
      @(negedge clk); standby = 1'b0;
      check("R8 standby", {7'b0, fe}, 8'h00);
      bus_write(1'b1, 8'hFF);
      bus_read(1'b1, d); check("R6 write one", d, 8'h00);

      // R7 no reception while disabled
      rx_en = 1'b0;
      send(8'h33, 1'b1, 1'b1, 1'b0);
      rx_en = 1'b1;
      bus_read(1'b1, d); check("R7 disabled", d, 8'h00);

      // R9 glitch rejection
      @(negedge clk); rxd = 1'b0;
      repeat (3) @(negedge clk); rxd = 1'b1;
      repeat (200) @(negedge clk);
      bus_read(1'b1, d); check("R9 glitch", d, 8'h00);
      bus_read(1'b0, d); check("R9 data", d, 8'h11);

      // R10 overrun
      send(8'h6B, 1'b1, 1'b1, 1'b0);
      send(8'h94, 1'b1, 1'b1, 1'b0);
      bus_read(1'b1, d); check("R10 status", d, 8'h05);
      bus_read(1'b0, d); check("R10 data", d, 8'h6B);
      clear_all();
      bus_read(1'b1, d); check("R10 cleared", d, 8'h00);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule